// File: doc/BRIEF.md
# CAN Bit-Time Timestamp and Timeout Unit

This unit is the time base of a CAN controller. It turns a one-cycle pulse per nominal bit time into a programmable time unit of 1 to 16 bit times. That unit drives two 16-bit counters. The timestamp counter can be held at zero, can count up once per unit, or can mirror an external 16-bit count. Its value is latched into a capture register on every start-of-frame pulse, for received and transmitted frames alike.

The timeout counter is a 16-bit down-counter that shares the same time unit. In continuous mode it starts from a programmed period, and software reloads it by writing the timeout value register. In FIFO-gated mode it waits at the period while a selected FIFO is empty. It starts when the first element is stored in that FIFO, and it reloads when the FIFO becomes empty again. When the down-counter reaches zero it sets a sticky flag. A wrap of the up-counter sets a second sticky flag.

The configuration fields (timestamp source, prescaler, timeout enable, timeout select and timeout period) accept writes only while both the initialization bit and the configuration-change bit are 1.

The timeout counter is controlled by a state machine with four states:
- TO_OFF: disabled.
- TO_ARMED: held at the period, waiting for the first store.
- TO_RUN: counting down.
- TO_DONE: expired and parked at zero.

Its transitions are:
- restart: an accepted configuration write goes to TO_OFF, TO_RUN or TO_ARMED.
- first_store: TO_ARMED goes to TO_RUN.
- expire: TO_RUN goes to TO_DONE.
- drained: TO_RUN or TO_DONE goes to TO_ARMED when the selected FIFO is empty.
- reload: in continuous mode, a value write in TO_RUN or TO_DONE goes to TO_RUN.

Top module: `cantime_base`

## Requirements
- R1: A unit tick occurs on every (psc+1)-th bit pulse, where psc is the 4-bit prescaler field. The prescaler count restarts at 0 on an accepted timestamp configuration write. While init_i is 1 the count is held at 0 and no unit ticks occur.
- R2: With timestamp source code 0 (code 3 behaves the same), the timestamp value is held at 0x0000.
- R3: With source code 1, the timestamp increments by one per unit tick. On the step from 0xFFFF to 0x0000 it sets the wrap flag.
- R4: With source code 1, a timestamp value write clears the timestamp to 0. This takes priority over an increment in the same cycle.
- R5: With source code 2, the timestamp equals ext_count_i one cycle later. A timestamp value write has no effect.
- R6: A start-of-frame pulse loads the capture output with the timestamp value present in that cycle, before any increment in the same cycle.
- R7: While the timeout enable bit is 0, the timeout value shows the period and the timeout flag is never set.
- R8: With the timeout enabled and select code 0 (continuous), the counter starts at the period and decrements once per unit tick. On reaching 0 it sets the timeout flag and stays at 0. A timeout value write reloads the period and counting continues.
- R9: Select codes 1, 2 and 3 gate the timeout counter on FIFO index 0 (Tx event), 1 (Rx 0) and 2 (Rx 1) of fifo_empty_i and fifo_store_i. The counter holds the period until a store into that FIFO and then counts down. It returns to the period whenever that FIFO is empty with no store in the same cycle. Timeout value writes are ignored in these modes.
- R10: Configuration writes are ignored unless init_i and cce_i are both 1 in the write cycle.
- R11: Both flags are sticky. Writing 1 to flag_clr_i bit 0 clears the wrap flag, and writing 1 to bit 1 clears the timeout flag. A set in the same cycle wins over a clear.
- R12: After reset, both counters, the capture register, the flags and all configuration fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle pulse per nominal bit time |
| sof_i | input | 1 | Start-of-frame pulse (Rx or Tx) |
| init_i | input | 1 | Initialization mode bit |
| cce_i | input | 1 | Configuration change enable bit |
| ts_cfg_we_i | input | 1 | Timestamp configuration write strobe |
| ts_cfg_src_i | input | 2 | Timestamp source code to write |
| ts_cfg_psc_i | input | 4 | Prescaler field to write |
| ts_val_we_i | input | 1 | Timestamp value register write strobe |
| to_cfg_we_i | input | 1 | Timeout configuration write strobe |
| to_cfg_en_i | input | 1 | Timeout enable to write |
| to_cfg_sel_i | input | 2 | Timeout select code to write |
| to_cfg_period_i | input | 16 | Timeout period to write |
| to_val_we_i | input | 1 | Timeout value register write strobe |
| ext_count_i | input | 16 | External timestamp count |
| fifo_empty_i | input | 3 | Empty level per FIFO |
| fifo_store_i | input | 3 | Element-stored pulse per FIFO |
| flag_clr_i | input | 2 | Write-1-to-clear strobes for the flags |
| ts_value_o | output | 16 | Timestamp counter value |
| ts_capture_o | output | 16 | Timestamp captured at start of frame |
| to_value_o | output | 16 | Timeout counter value |
| ts_wrap_flag_o | output | 1 | Timestamp wraparound flag |
| to_flag_o | output | 1 | Timeout occurred flag |
| ts_src_o | output | 2 | Current timestamp source code |
| ts_psc_o | output | 4 | Current prescaler field |
| to_en_o | output | 1 | Current timeout enable |
| to_sel_o | output | 2 | Current timeout select code |
| to_period_o | output | 16 | Current timeout period |

## Verification
The embedded assertions check the following on every cycle:
- The prescaler count never passes its limit.
- A held-zero timestamp stays zero, and an incrementing timestamp steps by exactly one per unit tick.
- A value write clears the timestamp, and the external mode follows its input.
- The capture register takes the prior value, and a wrap always raises its flag.
- The timeout counter sits at the period while armed and at zero once expired, and it decrements by one per unit while running.
- The locked configuration fields stay stable outside the unlock window, and both flags hold until cleared.

Only the bench scenarios can show end-to-end behaviour:
- Long-run counts equal the bit-pulse total divided by the programmed unit.
- The wrap happens after exactly 65536 units.
- Only the selected FIFO starts the timeout.
- A drained FIFO reloads the timeout.
- INIT suspends counting.

// File: rtl/cantime_pkg.sv
package cantime_pkg;

    typedef enum logic [1:0] {
        TS_ZERO   = 2'd0,
        TS_COUNT  = 2'd1,
        TS_EXTERN = 2'd2,
        TS_RSVD   = 2'd3
    } ts_src_e;

    typedef enum logic [1:0] {
        TO_OFF   = 2'd0,
        TO_ARMED = 2'd1,
        TO_RUN   = 2'd2,
        TO_DONE  = 2'd3
    } to_state_e;

endpackage

// File: rtl/cantime_prescaler.sv
module cantime_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick_i,
    input  logic             hold_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             unit_tick_o
);

    logic [PSC_W-1:0] cnt_q;

    assign unit_tick_o = bit_tick_i && !hold_i && !restart_i && (cnt_q == psc_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_i || restart_i) begin
            cnt_q <= '0;
        end else if (bit_tick_i) begin
            cnt_q <= unit_tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R1: the prescaler count never runs past the programmed limit
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= psc_i);

    // R1: while held, the count sits at zero on the next cycle
    a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> cnt_q == '0);

endmodule

// File: rtl/cantime_stamp.sv
module cantime_stamp
    import cantime_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_tick_i,
    input  ts_src_e          src_i,
    input  logic             val_we_i,
    input  logic [CNT_W-1:0] ext_i,
    input  logic             sof_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] value_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] ts_q, ts_d;
    logic [CNT_W-1:0] cap_q;
    logic             wrap_q, wrap_set;

    always_comb begin
        ts_d     = ts_q;
        wrap_set = 1'b0;
        unique case (src_i)
            TS_COUNT: begin
                if (val_we_i) begin
                    ts_d = '0;
                end else if (unit_tick_i) begin
                    ts_d     = ts_q + 1'b1;
                    wrap_set = (ts_q == ALL_ONES);
                end
            end
            TS_EXTERN: ts_d = ext_i;
            TS_ZERO,
            TS_RSVD:   ts_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q   <= '0;
            cap_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            ts_q   <= ts_d;
            wrap_q <= wrap_set | (wrap_q & ~clr_i);
            if (sof_i) begin
                cap_q <= ts_q;
            end
        end
    end

    assign value_o   = ts_q;
    assign capture_o = cap_q;
    assign wrap_o    = wrap_q;

    // R2: zero source keeps the counter at zero
    a_r2_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == TS_ZERO) |=> value_o == '0);

    // R3: counting mode advances by exactly one per unit
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == TS_COUNT && unit_tick_i && !val_we_i) |=> value_o == $past(value_o) + 1'b1);

    // R3: a wrap always raises the flag
    a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == TS_COUNT && unit_tick_i && !val_we_i && value_o == ALL_ONES) |=> wrap_o);

    // R4: a value write in counting mode clears the counter
    a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == TS_COUNT && val_we_i) |=> value_o == '0);

    // R5: external mode follows its input one cycle later
    a_r5_follow_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == TS_EXTERN) |=> value_o == $past(ext_i));

    // R6: start of frame latches the value seen in that cycle
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> capture_o == $past(value_o));

    // R11: the wrap flag holds until cleared
    a_r11_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !clr_i) |=> wrap_o);

endmodule

// File: rtl/cantime_timeout.sv
module cantime_timeout
    import cantime_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_FIFO = 3,
    parameter int SEL_W    = $clog2(NUM_FIFO + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                unit_tick_i,
    input  logic                cfg_we_i,
    input  logic                cfg_en_i,
    input  logic [SEL_W-1:0]    cfg_sel_i,
    input  logic [CNT_W-1:0]    cfg_period_i,
    input  logic                val_we_i,
    input  logic [NUM_FIFO-1:0] fifo_empty_i,
    input  logic [NUM_FIFO-1:0] fifo_store_i,
    input  logic                clr_i,
    output logic [CNT_W-1:0]    value_o,
    output logic                flag_o,
    output logic                en_o,
    output logic [SEL_W-1:0]    sel_o,
    output logic [CNT_W-1:0]    period_o
);

    to_state_e        st_q, st_d;
    logic [CNT_W-1:0] val_q, val_d;
    logic             flag_q, hit;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] period_q;
    logic             cont;
    logic             sel_empty, sel_store, drained;

    assign cont = (sel_q == '0);

    always_comb begin
        sel_empty = 1'b0;
        sel_store = 1'b0;
        for (int i = 0; i < NUM_FIFO; i++) begin
            if (sel_q == SEL_W'(i + 1)) begin
                sel_empty = fifo_empty_i[i];
                sel_store = fifo_store_i[i];
            end
        end
    end

    assign drained = !cont && sel_empty && !sel_store;

    // next state and counter value
    always_comb begin
        st_d  = st_q;
        val_d = val_q;
        hit   = 1'b0;
        if (cfg_we_i) begin
            val_d = cfg_period_i;
            if (!cfg_en_i) begin
                st_d = TO_OFF;
            end else if (cfg_sel_i == '0) begin
                st_d = TO_RUN;
            end else begin
                st_d = TO_ARMED;
            end
        end else begin
            unique case (st_q)
                TO_OFF: begin
                    val_d = period_q;
                end
                TO_ARMED: begin
                    val_d = period_q;
                    if (sel_store) begin
                        st_d = TO_RUN;
                    end
                end
                TO_RUN: begin
                    if (cont && val_we_i) begin
                        val_d = period_q;
                    end else if (drained) begin
                        st_d  = TO_ARMED;
                        val_d = period_q;
                    end else if (unit_tick_i) begin
                        if (val_q <= CNT_W'(1)) begin
                            val_d = '0;
                            st_d  = TO_DONE;
                            hit   = 1'b1;
                        end else begin
                            val_d = val_q - 1'b1;
                        end
                    end
                end
                TO_DONE: begin
                    if (cont && val_we_i) begin
                        st_d  = TO_RUN;
                        val_d = period_q;
                    end else if (drained) begin
                        st_d  = TO_ARMED;
                        val_d = period_q;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= TO_OFF;
            val_q    <= '0;
            flag_q   <= 1'b0;
            en_q     <= 1'b0;
            sel_q    <= '0;
            period_q <= '0;
        end else begin
            st_q   <= st_d;
            val_q  <= val_d;
            flag_q <= hit | (flag_q & ~clr_i);
            if (cfg_we_i) begin
                en_q     <= cfg_en_i;
                sel_q    <= cfg_sel_i;
                period_q <= cfg_period_i;
            end
        end
    end

    // outputs
    always_comb begin
        value_o  = val_q;
        flag_o   = flag_q;
        en_o     = en_q;
        sel_o    = sel_q;
        period_o = period_q;
    end

    // R7: disabled counter never raises the flag
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TO_OFF && !flag_q) |=> !flag_o);

    // R8: an expired counter sits at zero
    a_r8_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TO_DONE) |-> value_o == '0);

    // R8: running counter steps down by one per unit
    a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TO_RUN && unit_tick_i && !cfg_we_i && !val_we_i && !drained && val_q > CNT_W'(1))
        |=> value_o == $past(value_o) - 1'b1);

    // R9: an armed counter holds the period
    a_r9_armed_period: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TO_ARMED) |-> value_o == period_o);

    // R11: the timeout flag holds until cleared
    a_r11_to_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/cantime_base.sv
module cantime_base
    import cantime_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PSC_W    = 4,
    parameter int NUM_FIFO = 3,
    parameter int SEL_W    = $clog2(NUM_FIFO + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick_i,
    input  logic                sof_i,
    input  logic                init_i,
    input  logic                cce_i,
    input  logic                ts_cfg_we_i,
    input  logic [1:0]          ts_cfg_src_i,
    input  logic [PSC_W-1:0]    ts_cfg_psc_i,
    input  logic                ts_val_we_i,
    input  logic                to_cfg_we_i,
    input  logic                to_cfg_en_i,
    input  logic [SEL_W-1:0]    to_cfg_sel_i,
    input  logic [CNT_W-1:0]    to_cfg_period_i,
    input  logic                to_val_we_i,
    input  logic [CNT_W-1:0]    ext_count_i,
    input  logic [NUM_FIFO-1:0] fifo_empty_i,
    input  logic [NUM_FIFO-1:0] fifo_store_i,
    input  logic [1:0]          flag_clr_i,
    output logic [CNT_W-1:0]    ts_value_o,
    output logic [CNT_W-1:0]    ts_capture_o,
    output logic [CNT_W-1:0]    to_value_o,
    output logic                ts_wrap_flag_o,
    output logic                to_flag_o,
    output logic [1:0]          ts_src_o,
    output logic [PSC_W-1:0]    ts_psc_o,
    output logic                to_en_o,
    output logic [SEL_W-1:0]    to_sel_o,
    output logic [CNT_W-1:0]    to_period_o
);

    logic             unlocked;
    logic             ts_cfg_ok, to_cfg_ok;
    logic             unit_tick;
    ts_src_e          src_q;
    logic [PSC_W-1:0] psc_q;

    assign unlocked  = init_i && cce_i;
    assign ts_cfg_ok = ts_cfg_we_i && unlocked;
    assign to_cfg_ok = to_cfg_we_i && unlocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= TS_ZERO;
            psc_q <= '0;
        end else if (ts_cfg_ok) begin
            src_q <= ts_src_e'(ts_cfg_src_i);
            psc_q <= ts_cfg_psc_i;
        end
    end

    assign ts_src_o = src_q;
    assign ts_psc_o = psc_q;

    cantime_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick_i  (bit_tick_i),
        .hold_i      (init_i),
        .restart_i   (ts_cfg_ok),
        .psc_i       (psc_q),
        .unit_tick_o (unit_tick)
    );

    cantime_stamp #(.CNT_W(CNT_W)) u_stamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .unit_tick_i (unit_tick),
        .src_i       (src_q),
        .val_we_i    (ts_val_we_i),
        .ext_i       (ext_count_i),
        .sof_i       (sof_i),
        .clr_i       (flag_clr_i[0]),
        .value_o     (ts_value_o),
        .capture_o   (ts_capture_o),
        .wrap_o      (ts_wrap_flag_o)
    );

    cantime_timeout #(.CNT_W(CNT_W), .NUM_FIFO(NUM_FIFO), .SEL_W(SEL_W)) u_to (
        .clk          (clk),
        .rst_n        (rst_n),
        .unit_tick_i  (unit_tick),
        .cfg_we_i     (to_cfg_ok),
        .cfg_en_i     (to_cfg_en_i),
        .cfg_sel_i    (to_cfg_sel_i),
        .cfg_period_i (to_cfg_period_i),
        .val_we_i     (to_val_we_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_store_i (fifo_store_i),
        .clr_i        (flag_clr_i[1]),
        .value_o      (to_value_o),
        .flag_o       (to_flag_o),
        .en_o         (to_en_o),
        .sel_o        (to_sel_o),
        .period_o     (to_period_o)
    );

    // R10: locked configuration does not change outside the unlock window
    a_r10_ts_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_i && cce_i) |=> $stable(ts_src_o) && $stable(ts_psc_o));

    a_r10_to_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_i && cce_i) |=> $stable(to_en_o) && $stable(to_sel_o) && $stable(to_period_o));

endmodule

// File: tb/test_cantime_base.sv
module test_cantime_base;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, sof = 1'b0, init = 1'b0, cce = 1'b0;
    logic        ts_cfg_we = 1'b0, ts_val_we = 1'b0, to_cfg_we = 1'b0, to_val_we = 1'b0;
    logic [1:0]  ts_cfg_src = '0, to_cfg_sel = '0, flag_clr = '0;
    logic [3:0]  ts_cfg_psc = '0;
    logic        to_cfg_en = 1'b0;
    logic [15:0] to_cfg_period = '0, ext_count = '0;
    logic [2:0]  fifo_empty = 3'b111, fifo_store = '0;
    logic [15:0] ts_value, ts_capture, to_value, to_period;
    logic        ts_wrap_flag, to_flag, to_en;
    logic [1:0]  ts_src, to_sel;
    logic [3:0]  ts_psc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cantime_base i_cantime_base (
        .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick), .sof_i(sof),
        .init_i(init), .cce_i(cce),
        .ts_cfg_we_i(ts_cfg_we), .ts_cfg_src_i(ts_cfg_src), .ts_cfg_psc_i(ts_cfg_psc),
        .ts_val_we_i(ts_val_we),
        .to_cfg_we_i(to_cfg_we), .to_cfg_en_i(to_cfg_en), .to_cfg_sel_i(to_cfg_sel),
        .to_cfg_period_i(to_cfg_period), .to_val_we_i(to_val_we),
        .ext_count_i(ext_count), .fifo_empty_i(fifo_empty), .fifo_store_i(fifo_store),
        .flag_clr_i(flag_clr),
        .ts_value_o(ts_value), .ts_capture_o(ts_capture), .to_value_o(to_value),
        .ts_wrap_flag_o(ts_wrap_flag), .to_flag_o(to_flag),
        .ts_src_o(ts_src), .ts_psc_o(ts_psc), .to_en_o(to_en), .to_sel_o(to_sel),
        .to_period_o(to_period)
    );

    function automatic logic [15:0] exp_ts(input int bits, input int psc);
        return 16'(bits / (psc + 1));
    endfunction

    function automatic logic [15:0] exp_to(input int period, input int units);
        return (units >= period) ? 16'd0 : 16'(period - units);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic ts_cfg(input logic [1:0] s, input logic [3:0] p, input logic ini, input logic cc);
        @(negedge clk);
        init = ini; cce = cc; ts_cfg_we = 1'b1; ts_cfg_src = s; ts_cfg_psc = p;
        @(negedge clk);
        ts_cfg_we = 1'b0; init = 1'b0; cce = 1'b0;
    endtask

    task automatic to_cfg(input logic en, input logic [1:0] s, input logic [15:0] per);
        @(negedge clk);
        init = 1'b1; cce = 1'b1; to_cfg_we = 1'b1; to_cfg_en = en; to_cfg_sel = s; to_cfg_period = per;
        @(negedge clk);
        to_cfg_we = 1'b0; init = 1'b0; cce = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            bit_tick = 1'b1;
            repeat (n) @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    task automatic pulse_ts_we();
        @(negedge clk); ts_val_we = 1'b1; @(negedge clk); ts_val_we = 1'b0;
    endtask

    task automatic pulse_to_we();
        @(negedge clk); to_val_we = 1'b1; @(negedge clk); to_val_we = 1'b0;
    endtask

    task automatic pulse_clr(input logic [1:0] c);
        @(negedge clk); flag_clr = c; @(negedge clk); flag_clr = '0;
    endtask

    task automatic pulse_store(input logic [2:0] s);
        @(negedge clk); fifo_store = s; @(negedge clk); fifo_store = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int          cnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12", "ts value", ts_value, 0);
        chk("R12", "capture", ts_capture, 0);
        chk("R12", "to value", to_value, 0);
        chk("R12", "flags", {ts_wrap_flag, to_flag}, 0);
        chk("R12", "config", {ts_src, ts_psc, to_en, to_sel, to_period}, 0);

        // R10: locked writes are ignored
        ts_cfg(2'd1, 4'd5, 1'b0, 1'b1);
        chk("R10", "src/psc with init 0", {ts_src, ts_psc}, 0);
        ts_cfg(2'd1, 4'd5, 1'b1, 1'b0);
        chk("R10", "src/psc with cce 0", {ts_src, ts_psc}, 0);
        ticks(6);
        chk("R10", "ts stays in zero source", ts_value, 0);

        // R2: zero source with ticks
        ts_cfg(2'd0, 4'd0, 1'b1, 1'b1);
        ticks(9);
        chk("R2", "ts held at zero", ts_value, 0);

        // R1 / R3: prescaled counting
        ts_cfg(2'd1, 4'd2, 1'b1, 1'b1);
        chk("R10", "unlocked write lands", {ts_src, ts_psc}, {2'd1, 4'd2});
        ticks(20);
        chk("R1", "ts after 20 bits psc 2", ts_value, exp_ts(20, 2));

        // R1: INIT suspends counting
        v = ts_value;
        @(negedge clk); init = 1'b1;
        ticks(7);
        @(negedge clk); init = 1'b0;
        chk("R1", "no advance during INIT", ts_value, v);
        ticks(3);
        chk("R1", "prescaler restarted after INIT", ts_value, v + 16'd1);

        // R4: value write clears
        pulse_ts_we();
        chk("R4", "ts cleared by write", ts_value, 0);

        // R1 / R3: random prescaler and bursty ticks
        for (int it = 0; it < 6; it++) begin
            int p;
            p = int'($urandom % 16);
            ts_cfg(2'd1, 4'(p), 1'b1, 1'b1);
            pulse_ts_we();
            cnt = 0;
            for (int k = 0; k < 120; k++) begin
                @(negedge clk);
                bit_tick = ($urandom % 3) != 0;
                if (bit_tick) cnt++;
            end
            @(negedge clk); bit_tick = 1'b0;
            chk("R3", "random count", ts_value, exp_ts(cnt, p));
        end

        // R6: capture without and with a coincident increment
        ts_cfg(2'd1, 4'd0, 1'b1, 1'b1);
        ticks(3);
        v = ts_value;
        @(negedge clk); sof = 1'b1; @(negedge clk); sof = 1'b0;
        chk("R6", "capture idle", ts_capture, v);
        @(negedge clk); sof = 1'b1; bit_tick = 1'b1; @(negedge clk); sof = 1'b0; bit_tick = 1'b0;
        chk("R6", "capture before increment", ts_capture, v);
        chk("R3", "increment with sof", ts_value, v + 16'd1);

        // R3: full wrap
        pulse_ts_we();
        ticks(65535);
        chk("R3", "ts at top", ts_value, 16'hFFFF);
        chk("R3", "no wrap flag yet", ts_wrap_flag, 0);
        ticks(1);
        chk("R3", "ts wrapped", ts_value, 0);
        chk("R3", "wrap flag set", ts_wrap_flag, 1);
        ticks(2);
        chk("R11", "wrap flag sticky", ts_wrap_flag, 1);
        pulse_clr(2'b10);
        chk("R11", "other clear bit ignored", ts_wrap_flag, 1);
        pulse_clr(2'b01);
        chk("R11", "wrap flag cleared", ts_wrap_flag, 0);

        // R5: external mode
        ts_cfg(2'd2, 4'd0, 1'b1, 1'b1);
        @(negedge clk); ext_count = 16'h1234;
        @(negedge clk);
        chk("R5", "follows ext", ts_value, 16'h1234);
        ext_count = 16'hBEEF;
        pulse_ts_we();
        chk("R5", "write ignored in ext mode", ts_value, 16'hBEEF);

        // R7: disabled timeout
        ts_cfg(2'd1, 4'd1, 1'b1, 1'b1);
        to_cfg(1'b0, 2'd0, 16'h0033);
        ticks(10);
        chk("R7", "disabled shows period", to_value, 16'h0033);
        chk("R7", "disabled no flag", to_flag, 0);

        // R8: continuous, psc 1, period 5
        to_cfg(1'b1, 2'd0, 16'd5);
        chk("R8", "starts at period", to_value, 5);
        ticks(8);
        chk("R8", "after 4 units", to_value, exp_to(5, 4));
        chk("R8", "flag not yet", to_flag, 0);
        ticks(2);
        chk("R8", "reached zero", to_value, 0);
        chk("R8", "timeout flag", to_flag, 1);
        ticks(4);
        chk("R8", "stays at zero", to_value, 0);
        pulse_to_we();
        chk("R8", "reload by write", to_value, 5);
        ticks(2);
        chk("R8", "counts after reload", to_value, 4);
        pulse_clr(2'b10);
        chk("R11", "timeout flag cleared", to_flag, 0);

        // R8: random continuous runs
        for (int it = 0; it < 4; it++) begin
            int p, per, b;
            p   = int'($urandom % 4);
            per = 1 + int'($urandom % 40);
            b   = int'($urandom % 150);
            ts_cfg(2'd1, 4'(p), 1'b1, 1'b1);
            to_cfg(1'b1, 2'd0, 16'(per));
            pulse_clr(2'b10);
            ticks(b);
            chk("R8", "random timeout value", to_value, exp_to(per, b / (p + 1)));
            chk("R8", "random timeout flag", to_flag, (b / (p + 1)) >= per);
        end
        pulse_clr(2'b10);

        // R9: gated on Rx FIFO 0 (select 2, index 1)
        ts_cfg(2'd1, 4'd0, 1'b1, 1'b1);
        fifo_empty = 3'b111;
        to_cfg(1'b1, 2'd2, 16'd4);
        ticks(5);
        chk("R9", "held while empty", to_value, 4);
        pulse_store(3'b001);
        ticks(2);
        chk("R9", "other FIFO does not start", to_value, 4);
        pulse_to_we();
        chk("R9", "value write ignored", to_value, 4);
        @(negedge clk); fifo_store = 3'b010; fifo_empty = 3'b101;
        @(negedge clk); fifo_store = 3'b000;
        ticks(3);
        chk("R9", "counting after first store", to_value, 1);
        ticks(1);
        chk("R9", "expired", to_value, 0);
        chk("R9", "timeout flag", to_flag, 1);
        @(negedge clk); fifo_empty = 3'b111;
        @(negedge clk);
        chk("R9", "reload on empty", to_value, 4);
        chk("R11", "flag survives reload", to_flag, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule